// File: doc/BRIEF.md
# Single-Word Load/Store Address and Writeback Resolver

This block runs one single-word memory transfer, either a load or a store, that may also update its base register. It captures the operands when the transfer starts. It then forms the effective address from the base and the offset, adding or subtracting the offset and applying it before or after the access. It issues one word-aligned memory request. In the response cycle it drives up to two register-file write ports: port A carries the loaded data, and port B carries the updated base.

For an unaligned load, the block rotates the fetched word so that the addressed byte lands in the low lane. For an unaligned store, the block clears the low address bits on the bus, but the base writeback keeps the full unaligned address. When the destination register and the base register are the same, the loaded value wins over the writeback. A store always sends the register value that was captured at the start. A form whose offset comes from a register-specified shift costs one extra cycle before the access.

Top module: `ls_wb_resolver`

## Requirements
- R1: After reset the block is idle: mem_req, done, wa_en and wb_en are all 0.
- R2: When start is accepted at a clock edge without reg_shift, mem_req is high for exactly the next cycle, and done is high for the cycle after that. With reg_shift set, one extra cycle with mem_req low comes between the start edge and the request.
- R3: With pre_index=0 (post-indexing), the access uses the captured base. Port B always writes base+offset (add_offset=1) or base-offset (add_offset=0) to index rn.
- R4: With pre_index=1, the access uses base±offset. Port B writes that same value only when wb_flag=1, and wb_en stays 0 otherwise.
- R5: mem_addr always has bits [1:0] equal to 0. The port B writeback value keeps the unaligned low bits.
- R6: On a load, port A writes index rd with mem_rdata rotated right by 8 times the low 2 bits of the effective address.
- R7: On a load with rd equal to rn, wa_en is 1 with the loaded value, and wb_en is 0, so the loaded value is the final register content.
- R8: On a store, mem_we is 1 during the request and mem_wdata equals the store_val captured at start, even when rd equals rn. wa_en stays 0.
- R9: start is ignored while a transfer is in progress. After done, the block returns to idle with mem_req low.
- R10: wa_en and wb_en are high only in the cycle where done is high, which is the cycle after mem_req, when mem_rdata is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| is_load | input | 1 | 1 = load, 0 = store |
| pre_index | input | 1 | 1 = apply offset before access |
| add_offset | input | 1 | 1 = add offset, 0 = subtract |
| wb_flag | input | 1 | Writeback request for pre-indexed form |
| reg_shift | input | 1 | Offset from register-specified shift (extra cycle) |
| base | input | DW | Base register value |
| offset | input | DW | Offset value |
| rd | input | RW | Data register index |
| rn | input | RW | Base register index |
| store_val | input | DW | Register value to store |
| mem_rdata | input | DW | Memory read word, valid in the done cycle |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | DW | Word-aligned memory address |
| mem_wdata | output | DW | Store data |
| done | output | 1 | Response cycle marker |
| wa_en | output | 1 | Port A write enable (load data) |
| wa_idx | output | RW | Port A register index |
| wa_data | output | DW | Port A write data |
| wb_en | output | 1 | Port B write enable (base writeback) |
| wb_idx | output | RW | Port B register index |
| wb_data | output | DW | Port B write data |

## Verification
The load write and the base writeback fall in the same done cycle. When rd equals rn, they compete for the same register. The bench provokes this with post-indexed and pre-indexed-with-writeback loads that use identical indices. It judges the result by requiring wa_en high with the rotated word and wb_en low. A matching store with equal indices must instead show the captured old value on mem_wdata and the new base on port B.

// File: rtl/ls_wb_resolver.sv
module ls_wb_resolver #(
  parameter int DW = 32,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_load,
  input  logic          pre_index,
  input  logic          add_offset,
  input  logic          wb_flag,
  input  logic          reg_shift,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] offset,
  input  logic [RW-1:0] rd,
  input  logic [RW-1:0] rn,
  input  logic [DW-1:0] store_val,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          done,
  output logic          wa_en,
  output logic [RW-1:0] wa_idx,
  output logic [DW-1:0] wa_data,
  output logic          wb_en,
  output logic [RW-1:0] wb_idx,
  output logic [DW-1:0] wb_data
);
  localparam int LB = $clog2(DW/8);
  localparam int SW = LB + 3;

  typedef enum logic [1:0] {S_IDLE, S_XTRA, S_ACC, S_RESP} st_t;
  st_t st;

  logic          l_load, l_pre, l_up, l_wb;
  logic [DW-1:0] l_base, l_off, l_sval;
  logic [RW-1:0] l_rd, l_rn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      l_load <= 1'b0;
      l_pre  <= 1'b0;
      l_up   <= 1'b0;
      l_wb   <= 1'b0;
      l_base <= '0;
      l_off  <= '0;
      l_sval <= '0;
      l_rd   <= '0;
      l_rn   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st     <= reg_shift ? S_XTRA : S_ACC;
          l_load <= is_load;
          l_pre  <= pre_index;
          l_up   <= add_offset;
          l_wb   <= wb_flag;
          l_base <= base;
          l_off  <= offset;
          l_sval <= store_val;
          l_rd   <= rd;
          l_rn   <= rn;
        end
        S_XTRA:  st <= S_ACC;
        S_ACC:   st <= S_RESP;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [DW-1:0]   stepped, eff, rot;
  logic [2*DW-1:0] dbl;
  logic [SW-1:0]   sh;
  logic            do_wb, clash;

  assign stepped = l_up ? (l_base + l_off) : (l_base - l_off);
  assign eff     = l_pre ? stepped : l_base;
  assign sh      = {eff[LB-1:0], 3'b000};
  assign dbl     = {mem_rdata, mem_rdata};
  assign rot     = dbl[sh +: DW];
  assign do_wb   = !l_pre || l_wb;
  assign clash   = l_load && (l_rd == l_rn);

  assign mem_req   = (st == S_ACC);
  assign mem_we    = mem_req && !l_load;
  assign mem_addr  = {eff[DW-1:LB], {LB{1'b0}}};
  assign mem_wdata = l_sval;
  assign done      = (st == S_RESP);
  assign wa_en     = done && l_load;
  assign wa_idx    = l_rd;
  assign wa_data   = rot;
  assign wb_en     = done && do_wb && !clash;
  assign wb_idx    = l_rn;
  assign wb_data   = stepped;
endmodule

module ls_wb_resolver_chk #(
  parameter int DW = 32,
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic          done,
  input logic          wa_en,
  input logic [RW-1:0] wa_idx,
  input logic          wb_en,
  input logic [RW-1:0] wb_idx
);
  p_addr_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  p_req_then_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> (done && !mem_req));
  p_wen_in_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en || wb_en) |-> done);
  p_no_dual_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wa_en && wb_en) |-> (wa_idx != wb_idx));
  p_store_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> !wa_en);
  p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind ls_wb_resolver ls_wb_resolver_chk #(.DW(DW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .done(done), .wa_en(wa_en), .wa_idx(wa_idx),
  .wb_en(wb_en), .wb_idx(wb_idx)
);

// File: tb/tb_ls_wb_resolver.sv
module tb_ls_wb_resolver;
  localparam int DW = 32;
  localparam int RW = 4;

  logic clk = 0, rst_n = 0;
  logic start = 0, is_load = 0, pre_index = 0, add_offset = 0, wb_flag = 0, reg_shift = 0;
  logic [DW-1:0] base = 0, offset = 0, store_val = 0, mem_rdata = 0;
  logic [RW-1:0] rd = 0, rn = 0;
  logic mem_req, mem_we, done, wa_en, wb_en;
  logic [DW-1:0] mem_addr, mem_wdata, wa_data, wb_data;
  logic [RW-1:0] wa_idx, wb_idx;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  ls_wb_resolver #(.DW(DW), .RW(RW)) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] ror(input logic [DW-1:0] v, input int n);
    logic [DW-1:0] r = v;
    for (int i = 0; i < n; i++) r = {r[0], r[DW-1:1]};
    return r;
  endfunction

  task automatic op(input bit ld, input bit pre, input bit up, input bit wb, input bit rs,
                    input logic [DW-1:0] b, input logic [DW-1:0] o,
                    input logic [RW-1:0] d, input logic [RW-1:0] n,
                    input logic [DW-1:0] sv, input logic [DW-1:0] rdw, input bit poke);
    logic [DW-1:0] st_val, ea, e_addr, e_rot;
    bit e_wb;
    st_val = up ? b + o : b - o;
    ea     = pre ? st_val : b;
    e_addr = {ea[DW-1:2], 2'b00};
    e_rot  = ror(rdw, 8 * int'(ea[1:0]));
    e_wb   = (!pre || wb) && !(ld && d == n);
    @(negedge clk);
    start = 1; is_load = ld; pre_index = pre; add_offset = up; wb_flag = wb; reg_shift = rs;
    base = b; offset = o; rd = d; rn = n; store_val = sv;
    @(negedge clk);
    start = 0;
    if (rs) begin
      chk(mem_req == 0, "R2 extra cycle no req", DW'(mem_req), 0);
      @(negedge clk);
    end
    chk(mem_req == 1, "R2 req", DW'(mem_req), 1);
    chk(mem_addr == e_addr, "R3/R4/R5 addr", mem_addr, e_addr);
    chk(mem_we == !ld, "R8 we", DW'(mem_we), DW'(!ld));
    if (!ld) chk(mem_wdata == sv, "R8 wdata", mem_wdata, sv);
    chk(done == 0 && wa_en == 0 && wb_en == 0, "R10 no early write", DW'({done, wa_en, wb_en}), 0);
    mem_rdata = rdw;
    if (poke) begin
      start = 1; base = 32'hDEAD0000; is_load = 0; reg_shift = 0;
    end
    @(negedge clk);
    chk(done == 1, "R2 done", DW'(done), 1);
    chk(wa_en == ld, "R6/R8 wa_en", DW'(wa_en), DW'(ld));
    if (ld) begin
      chk(wa_data == e_rot, "R6 rotate", wa_data, e_rot);
      chk(wa_idx == d, "R6 wa_idx", DW'(wa_idx), DW'(d));
    end
    chk(wb_en == e_wb, "R3/R4/R7 wb_en", DW'(wb_en), DW'(e_wb));
    if (e_wb) begin
      chk(wb_data == st_val, "R3/R4/R5 wb_data", wb_data, st_val);
      chk(wb_idx == n, "R3 wb_idx", DW'(wb_idx), DW'(n));
    end
    if (poke) start = 0;
    @(negedge clk);
    chk(mem_req == 0 && done == 0, "R9 idle after done", DW'({mem_req, done}), 0);
  endtask

  task automatic t_reset;
    chk(mem_req == 0 && done == 0 && wa_en == 0 && wb_en == 0, "R1 reset",
        DW'({mem_req, done, wa_en, wb_en}), 0);
  endtask
  task automatic t_post_load;    op(1,0,1,0,0, 32'h1000, 32'h10, 3, 5, 0, 32'hAABBCCDD, 0); endtask
  task automatic t_pre_nowb;     op(1,1,0,0,0, 32'h2000, 32'h8, 1, 6, 0, 32'h01020304, 0); endtask
  task automatic t_pre_wb_store; op(0,1,1,1,0, 32'h3000, 32'h4, 2, 2, 32'h12345678, 0, 0); endtask
  task automatic t_unal_load;    op(1,1,1,1,0, 32'h4001, 32'h2, 7, 8, 0, 32'h11223344, 0); endtask
  task automatic t_unal_load1;   op(1,0,1,0,0, 32'h4005, 32'h0, 9, 10, 0, 32'hA1B2C3D4, 0); endtask
  task automatic t_conflict_r7;  op(1,0,1,0,0, 32'h5000, 32'h4, 4, 4, 0, 32'hCAFEF00D, 0); endtask
  task automatic t_conflict_pre; op(1,1,0,1,0, 32'h5102, 32'h0, 11, 11, 0, 32'h55667788, 0); endtask
  task automatic t_unal_store;   op(0,0,0,0,0, 32'h6002, 32'h10, 12, 13, 32'h0BADBEEF, 0, 0); endtask
  task automatic t_regshift;     op(1,1,1,1,1, 32'h7000, 32'h20, 14, 15, 0, 32'h76543210, 0); endtask
  task automatic t_busy_r9;      op(0,1,1,0,0, 32'h8000, 32'h4, 0, 1, 32'h00FF00FF, 0, 1); endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    t_reset;
    repeat (2) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_post_load;
    t_pre_nowb;
    t_pre_wb_store;
    t_unal_load;
    t_unal_load1;
    t_conflict_r7;
    t_conflict_pre;
    t_unal_store;
    t_regshift;
    t_busy_r9;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule